// File: doc/BRIEF.md
# Audio DAC Mute Pin Sequencer

This block drives an external mute-control pin that sits beside a multichannel audio DAC. The pin is left floating (output enable low) while the converter is powering up or while the power-down control bit is set. At all other times, the pin is driven to one of two levels. Software can choose a level directly through a manual mode. Otherwise, an automatic mode asserts the pin when one of three conditions holds: every channel carries zero data, every channel is muted, or the serial-port clock-error flag is set.

An automatic assertion never reaches the pin at once. First the block raises a soft-mute request towards the DAC channels. It then counts a programmable number of sample periods, and only after that does it drive the pin to its active level. Release runs in the reverse order. The pin goes inactive first, and the soft-mute request is held until the next sample period has started. The active level of the pin is chosen by a configuration input. A one-cycle strobe, `sample_tick`, marks each sample period.

The sequencer has six states:
- FLOAT: the pin is undriven.
- IDLE: the pin is driven inactive.
- LEAD: soft mute is on and the lead count is running.
- ACTIVE: the pin is active and soft mute is on.
- TRAIL: the pin is inactive and soft mute is still held.
- MANUAL: the pin follows the register value.

The state transitions are:
- Any state goes to FLOAT when a float condition is present.
- FLOAT goes to IDLE when the condition clears.
- IDLE goes to LEAD on an automatic request.
- LEAD goes to ACTIVE when the count reaches `lead_samples`.
- LEAD goes back to IDLE if the request drops (abort).
- ACTIVE goes to TRAIL when the request drops.
- TRAIL goes to IDLE on the next `sample_tick`.
- TRAIL goes to LEAD if the request returns.
- IDLE, LEAD, ACTIVE and TRAIL go to MANUAL while manual mode is selected.
- MANUAL goes to IDLE when manual mode is deselected.

Top module: `mute_pin_ctrl`

## Requirements
- R1: While `powering_up` or `pwr_down` is high, `pin_oe` is 0 in the same cycle, `pin_out` shows the inactive level, and `soft_mute_req` is 0 from the next clock edge on.
- R2: In manual mode (`man_mode`=1, no float condition), one edge after selection the pin is at its active level when `man_value`=1 and at its inactive level when `man_value`=0. `soft_mute_req` is 0 in this mode.
- R3: With `auto_en`=1, all bits of `zero_flags` set causes an assertion.
- R4: With `auto_en`=1, all bits of `ch_muted` set causes an assertion.
- R5: With `auto_en`=1, `clk_err`=1 causes an assertion.
- R6: No automatic assertion occurs for a partial set of zero or mute flags (including a mix that covers every channel only when the two sets are combined), or when `auto_en`=0.
- R7: The active pin level is 1 when `active_high`=1 and 0 when `active_high`=0. The inactive level is the complement.
- R8: `soft_mute_req` rises one edge after an automatic request appears while the pin is still inactive. The pin becomes active at the first edge at which the count of `sample_tick` pulses seen in LEAD equals `lead_samples`. With `lead_samples`=2 and back-to-back ticks, this is the third edge.
- R9: When the automatic request drops in ACTIVE, the pin goes inactive at the next edge while `soft_mute_req` stays 1. `soft_mute_req` clears at the edge where a `sample_tick` is seen.
- R10: A request that drops during LEAD returns the block to IDLE with `soft_mute_req` 0, and the pin never goes active.
- R11: Manual mode takes priority over an automatic request in IDLE, LEAD, ACTIVE or TRAIL. The pin follows `man_value`, and `soft_mute_req` clears.
- R12: During and right after reset, `pin_oe` and `soft_mute_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle strobe per sample period |
| powering_up | input | 1 | Converter power-up in progress |
| pwr_down | input | 1 | Power-down control bit |
| man_mode | input | 1 | Select manual pin control |
| man_value | input | 1 | Manual pin value (1 = active) |
| auto_en | input | 1 | Enable automatic assertion |
| active_high | input | 1 | Pin polarity, 1 = active high |
| lead_samples | input | CNT_W | Sample periods between soft mute and pin assertion |
| zero_flags | input | NUM_CH | Per-channel zero-data detect |
| ch_muted | input | NUM_CH | Per-channel mute status |
| clk_err | input | 1 | Serial-port clock error |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable (0 = high impedance) |
| soft_mute_req | output | 1 | Request to soft-mute the DAC channels |

## Verification
The bench checks the order of events around an assertion. A design that drives the pin in the same edge as the soft-mute request, or that drops soft mute together with the pin, fails the lead and trail checks. The edge-exact lead count with `lead_samples`=2 catches an off-by-one count, which would assert one edge early or late. Mixed zero and mute flags that cover all channels only together catch a design that ORs the two per-channel sets before reduction. An abort in LEAD, a float during ACTIVE and a switch to manual during LEAD expose designs that latch the pin active, hold soft mute, or drive the pin while floating.

// File: rtl/mute_pin_pkg.sv
`timescale 1ns/1ps
package mute_pin_pkg;

    typedef enum logic [2:0] {
        ST_FLOAT  = 3'd0,
        ST_IDLE   = 3'd1,
        ST_LEAD   = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_TRAIL  = 3'd4,
        ST_MANUAL = 3'd5
    } mute_st_e;

endpackage

// File: rtl/mute_cond.sv
`timescale 1ns/1ps
module mute_cond #(
    parameter int NUM_CH = 8
) (
    input  logic              auto_en,
    input  logic [NUM_CH-1:0] zero_flags,
    input  logic [NUM_CH-1:0] ch_muted,
    input  logic              clk_err,
    output logic              auto_req
);
    // Running AND chains, one link per channel
    logic [NUM_CH:0] zero_chain;
    logic [NUM_CH:0] mute_chain;

    assign zero_chain[0] = 1'b1;
    assign mute_chain[0] = 1'b1;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign zero_chain[g+1] = zero_chain[g] & zero_flags[g];
        assign mute_chain[g+1] = mute_chain[g] & ch_muted[g];
    end

    always_comb begin
        auto_req = auto_en & (zero_chain[NUM_CH] | mute_chain[NUM_CH] | clk_err);
    end

endmodule

// File: rtl/mute_seq_fsm.sv
`timescale 1ns/1ps
module mute_seq_fsm
    import mute_pin_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             float_now,
    input  logic             man_mode,
    input  logic             auto_req,
    input  logic             sample_tick,
    input  logic [CNT_W-1:0] lead_samples,
    output mute_st_e         st_q,
    output logic             soft_mute_req
);
    mute_st_e         st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             lead_done;

    assign lead_done = (cnt_q == lead_samples);

    // State register and lead counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FLOAT;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != ST_LEAD) begin
                cnt_q <= '0;
            end else if (sample_tick && !lead_done) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (float_now) begin
            st_d = ST_FLOAT;
        end else begin
            unique case (st_q)
                ST_FLOAT:  st_d = ST_IDLE;
                ST_IDLE: begin
                    if (man_mode)      st_d = ST_MANUAL;
                    else if (auto_req) st_d = ST_LEAD;
                end
                ST_LEAD: begin
                    if (man_mode)       st_d = ST_MANUAL;
                    else if (!auto_req) st_d = ST_IDLE;
                    else if (lead_done) st_d = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (man_mode)       st_d = ST_MANUAL;
                    else if (!auto_req) st_d = ST_TRAIL;
                end
                ST_TRAIL: begin
                    if (man_mode)         st_d = ST_MANUAL;
                    else if (auto_req)    st_d = ST_LEAD;
                    else if (sample_tick) st_d = ST_IDLE;
                end
                ST_MANUAL: begin
                    if (!man_mode) st_d = ST_IDLE;
                end
                default:   st_d = ST_FLOAT;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (st_q)
            ST_LEAD, ST_ACTIVE, ST_TRAIL: soft_mute_req = 1'b1;
            default:                      soft_mute_req = 1'b0;
        endcase
    end

    AST_FLOAT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        float_now |=> (st_q == ST_FLOAT)); // R1

    AST_LEAD_BEFORE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACTIVE && $past(st_q) != ST_ACTIVE) |-> ($past(st_q) == ST_LEAD)); // R8

    AST_TRAIL_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACTIVE && !auto_req && !man_mode && !float_now) |=> (st_q == ST_TRAIL)); // R9

    AST_MANUAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (man_mode && !float_now && st_q != ST_FLOAT) |=> (st_q == ST_MANUAL)); // R11

endmodule

// File: rtl/mute_pin_drv.sv
`timescale 1ns/1ps
module mute_pin_drv
    import mute_pin_pkg::*;
(
    input  mute_st_e st_q,
    input  logic     float_now,
    input  logic     man_value,
    input  logic     active_high,
    output logic     pin_asserted,
    output logic     pin_out,
    output logic     pin_oe
);
    always_comb begin
        unique case (st_q)
            ST_ACTIVE: pin_asserted = 1'b1;
            ST_MANUAL: pin_asserted = man_value;
            default:   pin_asserted = 1'b0;
        endcase
        pin_oe  = (st_q != ST_FLOAT) && !float_now;
        pin_out = (pin_asserted && pin_oe) ? active_high : ~active_high;
    end

endmodule

// File: rtl/mute_pin_ctrl.sv
`timescale 1ns/1ps
module mute_pin_ctrl
    import mute_pin_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              powering_up,
    input  logic              pwr_down,
    input  logic              man_mode,
    input  logic              man_value,
    input  logic              auto_en,
    input  logic              active_high,
    input  logic [CNT_W-1:0]  lead_samples,
    input  logic [NUM_CH-1:0] zero_flags,
    input  logic [NUM_CH-1:0] ch_muted,
    input  logic              clk_err,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              soft_mute_req
);
    logic     float_now;
    logic     auto_req;
    logic     pin_asserted;
    mute_st_e st_q;

    assign float_now = powering_up | pwr_down;

    mute_cond #(.NUM_CH(NUM_CH)) u_cond (
        .auto_en    (auto_en),
        .zero_flags (zero_flags),
        .ch_muted   (ch_muted),
        .clk_err    (clk_err),
        .auto_req   (auto_req)
    );

    mute_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .float_now     (float_now),
        .man_mode      (man_mode),
        .auto_req      (auto_req),
        .sample_tick   (sample_tick),
        .lead_samples  (lead_samples),
        .st_q          (st_q),
        .soft_mute_req (soft_mute_req)
    );

    mute_pin_drv u_drv (
        .st_q         (st_q),
        .float_now    (float_now),
        .man_value    (man_value),
        .active_high  (active_high),
        .pin_asserted (pin_asserted),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe)
    );

    AST_SOFT_MUTE_COVERS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_asserted && st_q != ST_MANUAL) |-> soft_mute_req); // R8

    AST_FLOAT_NO_SOFT_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(float_now) |-> !soft_mute_req); // R1

endmodule

// File: tb/mute_pin_ctrl_test.sv
`timescale 1ns/1ps
module mute_pin_ctrl_test;
    localparam int NCH = 8;
    localparam int CW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_tick = 1'b0, powering_up = 1'b0, pwr_down = 1'b0;
    logic man_mode = 1'b0, man_value = 1'b0, auto_en = 1'b0, active_high = 1'b1;
    logic [CW-1:0]  lead_samples = '0;
    logic [NCH-1:0] zero_flags = '0, ch_muted = '0;
    logic clk_err = 1'b0;
    logic pin_out, pin_oe, soft_mute_req;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    mute_pin_ctrl #(.NUM_CH(NCH), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .powering_up(powering_up), .pwr_down(pwr_down),
        .man_mode(man_mode), .man_value(man_value), .auto_en(auto_en),
        .active_high(active_high), .lead_samples(lead_samples),
        .zero_flags(zero_flags), .ch_muted(ch_muted), .clk_err(clk_err),
        .pin_out(pin_out), .pin_oe(pin_oe), .soft_mute_req(soft_mute_req)
    );

    typedef struct packed {
        logic           pu, pd, mm, mv, ae, pol;
        logic [NCH-1:0] zero, muted;
        logic           cerr;
        logic           e_oe, e_out, e_sm;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1,0,0,0,1,1,8'hFF,8'h00,0, 0,0,0}, // R1 powering up
        '{0,1,0,0,1,1,8'hFF,8'h00,0, 0,0,0}, // R1 power-down bit
        '{0,0,0,0,1,1,8'hFF,8'h00,0, 1,1,1}, // R3 all zero
        '{0,0,0,0,1,1,8'h7F,8'h00,0, 1,0,0}, // R6 partial zero
        '{0,0,0,0,1,1,8'h00,8'hFF,0, 1,1,1}, // R4 all muted
        '{0,0,0,0,1,1,8'h01,8'hFE,0, 1,0,0}, // R6 mixed sets
        '{0,0,0,0,1,1,8'h00,8'h00,1, 1,1,1}, // R5 clock error
        '{0,0,0,0,0,1,8'hFF,8'hFF,1, 1,0,0}, // R6 auto disabled
        '{0,0,1,1,0,1,8'h00,8'h00,0, 1,1,0}, // R2 manual active
        '{0,0,1,0,1,1,8'h00,8'h00,1, 1,0,0}, // R11 manual over auto
        '{0,0,0,0,1,0,8'h00,8'h00,1, 1,0,1}, // R7 active low asserted
        '{0,0,0,0,1,0,8'h00,8'h00,0, 1,1,0}, // R7 active low idle
        '{0,0,1,1,0,0,8'h00,8'h00,0, 1,0,0}, // R7 R2 manual active low
        '{0,1,1,1,0,0,8'h00,8'h00,0, 0,1,0}  // R1 float over manual
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n, input logic tk);
        for (int i = 0; i < n; i++) begin
            sample_tick = tk;
            @(negedge clk);
        end
        sample_tick = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        // R12 reset state
        @(negedge clk);
        chk("R12", "oe in reset", pin_oe, 1'b0);
        chk("R12", "sm in reset", soft_mute_req, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12", "oe after reset", pin_oe, 1'b0);
        chk("R12", "sm after reset", soft_mute_req, 1'b0);
        cycles(1, 1'b0);
        chk("R12", "oe driven after release", pin_oe, 1'b1);

        // Table walk, lead of zero samples
        lead_samples = '0;
        for (int v = 0; v < NV; v++) begin
            powering_up = VECS[v].pu; pwr_down = VECS[v].pd;
            man_mode = VECS[v].mm; man_value = VECS[v].mv;
            auto_en = VECS[v].ae; active_high = VECS[v].pol;
            zero_flags = VECS[v].zero; ch_muted = VECS[v].muted;
            clk_err = VECS[v].cerr;
            cycles(4, 1'b1);
            chk($sformatf("vec%0d", v), "oe", pin_oe, VECS[v].e_oe);
            chk($sformatf("vec%0d", v), "out", pin_out, VECS[v].e_out);
            chk($sformatf("vec%0d", v), "sm", soft_mute_req, VECS[v].e_sm);
        end

        // Quiet, active high
        pwr_down = 0; powering_up = 0; man_mode = 0; man_value = 0;
        auto_en = 1; active_high = 1; zero_flags = '0; ch_muted = '0; clk_err = 0;
        cycles(3, 1'b1);

        // R8 lead timing with two samples
        lead_samples = 8'd2;
        zero_flags = '1;
        cycles(1, 1'b0);
        chk("R8", "sm raised", soft_mute_req, 1'b1);
        chk("R8", "pin held before lead", pin_out, 1'b0);
        cycles(1, 1'b1);
        chk("R8", "pin held after tick 1", pin_out, 1'b0);
        cycles(1, 1'b1);
        chk("R8", "pin held after tick 2", pin_out, 1'b0);
        cycles(1, 1'b0);
        chk("R8", "pin active third edge", pin_out, 1'b1);

        // R9 release ordering
        zero_flags = '0;
        cycles(1, 1'b0);
        chk("R9", "pin released", pin_out, 1'b0);
        chk("R9", "sm held", soft_mute_req, 1'b1);
        cycles(1, 1'b0);
        chk("R9", "sm held without tick", soft_mute_req, 1'b1);
        cycles(1, 1'b1);
        chk("R9", "sm cleared on tick", soft_mute_req, 1'b0);

        // R10 abort in lead
        lead_samples = 8'd3;
        clk_err = 1;
        cycles(1, 1'b1);
        chk("R10", "sm raised", soft_mute_req, 1'b1);
        clk_err = 0;
        cycles(1, 1'b1);
        chk("R10", "sm dropped", soft_mute_req, 1'b0);
        chk("R10", "pin never active", pin_out, 1'b0);
        cycles(4, 1'b1);
        chk("R10", "pin still inactive", pin_out, 1'b0);

        // R11 manual during lead
        ch_muted = '1;
        cycles(1, 1'b0);
        chk("R11", "lead entered", soft_mute_req, 1'b1);
        man_mode = 1; man_value = 0;
        cycles(1, 1'b0);
        chk("R11", "sm cleared by manual", soft_mute_req, 1'b0);
        chk("R11", "pin follows manual 0", pin_out, 1'b0);
        man_value = 1;
        #1;
        chk("R2", "pin follows manual 1", pin_out, 1'b1);
        man_mode = 0; man_value = 0;
        lead_samples = 8'd0;
        cycles(3, 1'b1);
        chk("R4", "auto active after manual", pin_out, 1'b1);

        // R1 float during active
        pwr_down = 1;
        #1;
        chk("R1", "oe drops same cycle", pin_oe, 1'b0);
        chk("R1", "out inactive level", pin_out, 1'b0);
        @(negedge clk);
        chk("R1", "sm cleared in float", soft_mute_req, 1'b0);
        pwr_down = 0;
        cycles(1, 1'b0);
        chk("R1", "oe back after float", pin_oe, 1'b1);

        summary();
    end
endmodule